// File: doc/BRIEF.md
# Computation Unit Sequencer

This controller runs one operation at a time on behalf of a single execution pipeline. An operation is accepted from an issue port together with a two-bit operation class. The controller then asks for its source operands, hands them to the pipeline, waits for the result, and asks for permission to write that result back. The operand and result holding registers carry data only and no register numbers. Each active unit therefore acts as a set of anonymous rename slots, and choosing the register file entries is left to logic outside it.

The controller never counts cycles. It moves from one step to the next only when the party it waits on acknowledges: a read grant, pipeline ready, result valid, or a write grant. The pipeline may therefore take any number of cycles. An operation class that produces no result, such as a store, finishes directly after its operands are accepted by the pipeline. Any other class must wait until its result has been written back.

Top module: `cu_sequencer`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, leaves `busy`, `done`, `rd_req`, `pl_valid` and `wr_req` all low.
- R2: When `iss_valid` is high at an edge while the unit is idle, `busy` and `rd_req` are both high from the next cycle.
- R3: An `iss_valid` seen while `busy` is high is ignored. The class and sequence of the operation in flight are unchanged, and the unit returns to idle once it completes.
- R4: `rd_req` stays high until a cycle with `rd_gnt` high. On that edge `rd_data` is captured, and from the next cycle it is shown on `pl_ops`, with `pl_valid` high and `pl_cls` equal to the issued class.
- R5: `pl_valid` stays high with `pl_ops` unchanged until a cycle with `pl_ready` high.
- R6: For a class with bit 0 clear, which produces a result, `done` and `wr_req` stay low between dispatch and the result, whatever the number of cycles. `done` also stays low until the write is granted.
- R7: After `res_valid` is seen while waiting for a result, `wr_req` goes high in the next cycle with `wr_data` equal to the captured `res_data`. Both hold until a cycle with `wr_gnt` high.
- R8: For a class with bit 0 set, which produces no result, `done` is high in the cycle after the pipeline accepts the operands, and `wr_req` never rises.
- R9: A `res_valid` in the same cycle as `pl_valid && pl_ready`, for a result-producing class, is captured and written back like a later result.
- R10: `done` is high for exactly one cycle, while `busy` is still high. In the following cycle both are low.
- R11: A `res_valid` outside the wait for a result has no effect. It neither advances the unit nor alters `wr_data`.
- R12: `rd_gnt`, `pl_ready`, `res_valid` and `wr_gnt` seen while idle have no effect, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue strobe |
| iss_cls | input | 2 | Operation class; bit 0 set means no result |
| rd_req | output | 1 | Operand read request |
| rd_gnt | input | 1 | Operand read grant |
| rd_data | input | NOPER*W | Operand values, operand 0 in the low bits |
| pl_valid | output | 1 | Operands offered to the pipeline |
| pl_ready | input | 1 | Pipeline accepts the operands |
| pl_cls | output | 2 | Class of the operation in flight |
| pl_ops | output | NOPER*W | Latched operands |
| res_valid | input | 1 | Result-valid pulse from the pipeline |
| res_data | input | W | Result value |
| wr_req | output | 1 | Writeback request |
| wr_gnt | input | 1 | Writeback grant |
| wr_data | output | W | Latched result |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Operation completion pulse |

## Verification
Dispatch acceptance and result capture can fall in the same cycle when a pipeline returns its result with zero latency. The bench provokes this by raising `pl_ready` and `res_valid` together while the operands are offered. It then expects `wr_req` in the next cycle, carrying exactly that result, and no lost or duplicated writeback. A second overlap, a stray issue or result pulse arriving while another step is pending, is judged by watching the ports. The operation in flight must finish with its own class and data.

// File: rtl/cu_seq_pkg.sv
package cu_seq_pkg;

  localparam int CLS_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_WAIT_READ   = 3'd1,
    ST_DISPATCH    = 3'd2,
    ST_WAIT_RESULT = 3'd3,
    ST_WAIT_WRITE  = 3'd4,
    ST_DONE        = 3'd5
  } cu_state_t;

  // Bit 0 of the class marks an operation that produces no result.
  function automatic logic cls_has_result(input logic [CLS_W-1:0] cls);
    return !cls[0];
  endfunction

  // Advance only on the acknowledgement that the current blockage is gone.
  function automatic cu_state_t cu_next(
    input cu_state_t s,
    input logic      iss,
    input logic      has_res,
    input logic      rd_ack,
    input logic      pl_ack,
    input logic      res_ack,
    input logic      wr_ack
  );
    cu_state_t n;
    n = s;
    case (s)
      ST_IDLE:        if (iss)    n = ST_WAIT_READ;
      ST_WAIT_READ:   if (rd_ack) n = ST_DISPATCH;
      ST_DISPATCH: begin
        if (pl_ack) begin
          if (!has_res)     n = ST_DONE;
          else if (res_ack) n = ST_WAIT_WRITE;
          else              n = ST_WAIT_RESULT;
        end
      end
      ST_WAIT_RESULT: if (res_ack) n = ST_WAIT_WRITE;
      ST_WAIT_WRITE:  if (wr_ack)  n = ST_DONE;
      ST_DONE:        n = ST_IDLE;
      default:        n = ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cu_seq_fsm.sv
module cu_seq_fsm
  import cu_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [CLS_W-1:0] iss_cls,
  input  logic             rd_gnt,
  input  logic             pl_ready,
  input  logic             res_valid,
  input  logic             wr_gnt,
  output cu_state_t        state,
  output logic [CLS_W-1:0] cls_q,
  output logic             has_res,
  output logic             ev_issue,
  output logic             ev_read_done,
  output logic             ev_dispatch,
  output logic             ev_result,
  output logic             ev_write_done
);

  cu_state_t state_nx;

  assign has_res       = cls_has_result(cls_q);
  assign ev_issue      = (state == ST_IDLE) && iss_valid;
  assign ev_read_done  = (state == ST_WAIT_READ) && rd_gnt;
  assign ev_dispatch   = (state == ST_DISPATCH) && pl_ready;
  assign ev_result     = res_valid && has_res &&
                         ((state == ST_WAIT_RESULT) || ev_dispatch);
  assign ev_write_done = (state == ST_WAIT_WRITE) && wr_gnt;

  always_comb begin
    state_nx = cu_next(state, iss_valid, has_res, rd_gnt, pl_ready,
                       res_valid, wr_gnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cls_q <= '0;
    end else begin
      state <= state_nx;
      if (ev_issue) cls_q <= iss_cls;
    end
  end

endmodule

// File: rtl/cu_operand_latch.sv
module cu_operand_latch #(
  parameter int W     = 32,
  parameter int NOPER = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap,
  input  logic [NOPER*W-1:0] d,
  output logic [NOPER*W-1:0] q
);

  // One anonymous slot per operand; no register number is kept.
  for (genvar g = 0; g < NOPER; g++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)      slot_q <= '0;
      else if (cap) slot_q <= d[g*W +: W];
    end
    assign q[g*W +: W] = slot_q;
  end

endmodule

// File: rtl/cu_result_latch.sv
module cu_result_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

endmodule

// File: rtl/cu_sequencer.sv
module cu_sequencer
  import cu_seq_pkg::*;
#(
  parameter int W     = 32,
  parameter int NOPER = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iss_valid,
  input  logic [1:0]         iss_cls,
  output logic               rd_req,
  input  logic               rd_gnt,
  input  logic [NOPER*W-1:0] rd_data,
  output logic               pl_valid,
  input  logic               pl_ready,
  output logic [1:0]         pl_cls,
  output logic [NOPER*W-1:0] pl_ops,
  input  logic               res_valid,
  input  logic [W-1:0]       res_data,
  output logic               wr_req,
  input  logic               wr_gnt,
  output logic [W-1:0]       wr_data,
  output logic               busy,
  output logic               done
);

  cu_state_t        state;
  logic [CLS_W-1:0] cls_q;
  logic             has_res;
  logic             ev_issue;
  logic             ev_read_done;
  logic             ev_dispatch;
  logic             ev_result;
  logic             ev_write_done;

  cu_seq_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .iss_valid     (iss_valid),
    .iss_cls       (iss_cls),
    .rd_gnt        (rd_gnt),
    .pl_ready      (pl_ready),
    .res_valid     (res_valid),
    .wr_gnt        (wr_gnt),
    .state         (state),
    .cls_q         (cls_q),
    .has_res       (has_res),
    .ev_issue      (ev_issue),
    .ev_read_done  (ev_read_done),
    .ev_dispatch   (ev_dispatch),
    .ev_result     (ev_result),
    .ev_write_done (ev_write_done)
  );

  cu_operand_latch #(.W(W), .NOPER(NOPER)) u_opnd (
    .clk (clk),
    .rst (rst),
    .cap (ev_read_done),
    .d   (rd_data),
    .q   (pl_ops)
  );

  cu_result_latch #(.W(W)) u_res (
    .clk (clk),
    .rst (rst),
    .cap (ev_result),
    .d   (res_data),
    .q   (wr_data)
  );

  assign rd_req   = (state == ST_WAIT_READ);
  assign pl_valid = (state == ST_DISPATCH);
  assign wr_req   = (state == ST_WAIT_WRITE);
  assign done     = (state == ST_DONE);
  assign busy     = (state != ST_IDLE);
  assign pl_cls   = cls_q;

endmodule

// File: rtl/cu_seq_checker.sv
module cu_seq_checker #(
  parameter int W     = 32,
  parameter int NOPER = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               iss_valid,
  input logic               rd_req,
  input logic               rd_gnt,
  input logic               pl_valid,
  input logic               pl_ready,
  input logic [NOPER*W-1:0] pl_ops,
  input logic               res_valid,
  input logic [W-1:0]       res_data,
  input logic               wr_req,
  input logic               wr_gnt,
  input logic [W-1:0]       wr_data,
  input logic               busy,
  input logic               done,
  input logic               has_res,
  input logic               ev_dispatch
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_req && !pl_valid && !wr_req && !done));

  a_r2_issue_starts: assert property (@(posedge clk) disable iff (rst)
    (!busy && iss_valid) |=> (busy && rd_req));

  a_r3_issue_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && iss_valid) |=> busy);

  a_r4_read_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_gnt) |=> rd_req);

  a_r4_read_to_dispatch: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_gnt) |=> pl_valid);

  a_r5_dispatch_hold: assert property (@(posedge clk) disable iff (rst)
    (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_ops)));

  a_r6_no_early_done: assert property (@(posedge clk) disable iff (rst)
    (ev_dispatch && has_res) |=> !done);

  a_r7_write_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_data)));

  a_r8_noresult_done: assert property (@(posedge clk) disable iff (rst)
    (ev_dispatch && !has_res) |=> (done && !wr_req));

  a_r9_same_cycle_result: assert property (@(posedge clk) disable iff (rst)
    (ev_dispatch && has_res && res_valid) |=>
      (wr_req && wr_data == $past(res_data)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r10_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  a_r12_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!busy && !iss_valid) |=> !busy);

endmodule

bind cu_sequencer cu_seq_checker #(.W(W), .NOPER(NOPER)) u_cu_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .iss_valid   (iss_valid),
  .rd_req      (rd_req),
  .rd_gnt      (rd_gnt),
  .pl_valid    (pl_valid),
  .pl_ready    (pl_ready),
  .pl_ops      (pl_ops),
  .res_valid   (res_valid),
  .res_data    (res_data),
  .wr_req      (wr_req),
  .wr_gnt      (wr_gnt),
  .wr_data     (wr_data),
  .busy        (busy),
  .done        (done),
  .has_res     (has_res),
  .ev_dispatch (ev_dispatch)
);

// File: tb/test_cu_sequencer.sv
module test_cu_sequencer;

  localparam int W     = 32;
  localparam int NOPER = 2;

  logic               clk = 1'b0;
  logic               rst;
  logic               iss_valid;
  logic [1:0]         iss_cls;
  logic               rd_req;
  logic               rd_gnt;
  logic [NOPER*W-1:0] rd_data;
  logic               pl_valid;
  logic               pl_ready;
  logic [1:0]         pl_cls;
  logic [NOPER*W-1:0] pl_ops;
  logic               res_valid;
  logic [W-1:0]       res_data;
  logic               wr_req;
  logic               wr_gnt;
  logic [W-1:0]       wr_data;
  logic               busy;
  logic               done;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cu_sequencer #(.W(W), .NOPER(NOPER)) i_cu_sequencer (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_cls   (iss_cls),
    .rd_req    (rd_req),
    .rd_gnt    (rd_gnt),
    .rd_data   (rd_data),
    .pl_valid  (pl_valid),
    .pl_ready  (pl_ready),
    .pl_cls    (pl_cls),
    .pl_ops    (pl_ops),
    .res_valid (res_valid),
    .res_data  (res_data),
    .wr_req    (wr_req),
    .wr_gnt    (wr_gnt),
    .wr_data   (wr_data),
    .busy      (busy),
    .done      (done)
  );

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    iss_valid = 0; iss_cls = 0; rd_gnt = 0; rd_data = '0;
    pl_ready = 0; res_valid = 0; res_data = '0; wr_gnt = 0;
  endtask

  // One operation, driven step by step; poke adds stray pulses.
  task automatic run_op(input logic [1:0] cls, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] r,
                        input int rdd, input int pld, input int lat,
                        input int wrd, input bit same, input bit poke);
    iss_valid = 1; iss_cls = cls;
    tick();
    iss_valid = 0; iss_cls = 0;
    chk("R2 busy", busy, 1);
    chk("R2 rd_req", rd_req, 1);
    for (int i = 0; i < rdd; i++) begin
      if (poke) begin res_valid = 1; res_data = ~r; end
      tick();
      res_valid = 0;
      chk("R4 rd_req held", rd_req, 1);
      chk("R11 no advance", pl_valid, 0);
    end
    rd_gnt = 1; rd_data = {b, a};
    tick();
    rd_gnt = 0; rd_data = '0;
    chk("R4 pl_valid", pl_valid, 1);
    chk("R4 pl_ops", pl_ops, {b, a});
    chk("R4 pl_cls", pl_cls, cls);
    for (int i = 0; i < pld; i++) begin
      tick();
      chk("R5 pl_valid held", pl_valid, 1);
      chk("R5 pl_ops stable", pl_ops, {b, a});
    end
    pl_ready = 1;
    if (same) begin res_valid = 1; res_data = r; end
    tick();
    pl_ready = 0; res_valid = 0; res_data = '0;
    chk("R5 pl_valid drops", pl_valid, 0);
    if (cls[0]) begin
      chk("R8 done", done, 1);
      chk("R8 wr_req", wr_req, 0);
      tick();
      chk("R10 done clears", done, 0);
      chk("R10 busy clears", busy, 0);
      return;
    end
    if (!same) begin
      for (int i = 0; i < lat; i++) begin
        if (poke) begin iss_valid = 1; iss_cls = 2'b01; end
        chk("R6 done low", done, 0);
        chk("R6 wr_req low", wr_req, 0);
        tick();
        iss_valid = 0; iss_cls = 0;
        chk("R3 busy kept", busy, 1);
        chk("R3 class kept", pl_cls, cls);
      end
      res_valid = 1; res_data = r;
      tick();
      res_valid = 0; res_data = '0;
    end
    chk(same ? "R9 wr_req" : "R7 wr_req", wr_req, 1);
    chk(same ? "R9 wr_data" : "R7 wr_data", wr_data, r);
    for (int i = 0; i < wrd; i++) begin
      if (poke) begin res_valid = 1; res_data = ~r; end
      tick();
      res_valid = 0; res_data = '0;
      chk("R7 wr_req held", wr_req, 1);
      chk("R11 wr_data kept", wr_data, r);
      chk("R6 done waits write", done, 0);
    end
    wr_gnt = 1;
    tick();
    wr_gnt = 0;
    chk("R10 done", done, 1);
    chk("R10 busy in done", busy, 1);
    tick();
    chk("R10 done clears", done, 0);
    chk("R10 busy clears", busy, 0);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1;
    tick(); tick();
    rst = 0;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 pl_valid", pl_valid, 0);
    chk("R1 wr_req", wr_req, 0);
  endtask

  task automatic t_idle_noise();
    rd_gnt = 1; pl_ready = 1; res_valid = 1; wr_gnt = 1;
    tick();
    idle_inputs();
    chk("R12 busy", busy, 0);
    chk("R12 rd_req", rd_req, 0);
    tick();
    chk("R12 still idle", busy, 0);
  endtask

  task automatic t_basic();
    run_op(2'b00, 32'h1111_0001, 32'h2222_0002, 32'hA5A5_0003,
           2, 2, 5, 1, 0, 0);
  endtask

  task automatic t_no_wait();
    run_op(2'b10, 32'h0BAD_F00D, 32'h1234_5678, 32'h8765_4321,
           0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_long_latency_noise();
    run_op(2'b00, 32'hDEAD_0000, 32'h0000_BEEF, 32'hC0FF_EE00,
           3, 1, 40, 3, 0, 1);
  endtask

  task automatic t_store();
    run_op(2'b01, 32'h5555_AAAA, 32'hAAAA_5555, 32'h0, 1, 2, 0, 0, 0, 0);
    run_op(2'b11, 32'h0000_0001, 32'h0000_0002, 32'h0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    run_op(2'b00, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h7777_1234,
           1, 1, 0, 2, 1, 0);
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1;
    idle_inputs();
    tick();
    t_reset();
    t_idle_noise();
    t_basic();
    t_no_wait();
    t_store();
    t_same_cycle();
    t_long_latency_noise();
    t_basic();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule